// File: doc/BRIEF.md
# Multi-Kernel Workgroup Dispatch Scheduler

This block sits between a host-facing launch port and a group of compute units. Each launch names a kernel slot, gives the number of workgroups along three dimensions and says whether a notify flag should be raised when the kernel finishes. The slot number goes into an internal queue of pending kernels.

A scheduling pass walks that queue. It keeps offering workgroups of the kernel at the head for as long as the compute units accept them. When the compute units turn down a workgroup, that kernel rotates to the back of the queue and a per-pass failure count goes up. The pass then tries the next kernel, whose workgroups may be smaller and still fit. The pass stops once the queue holds no more kernels than the failure count. A new pass is armed one cycle after any launch or any workgroup-completion report.

Completion reports carry a kernel slot. When the last workgroup of a kernel reports back, the block pulses a done output with the kernel slot. It also sets that slot's notify flag if the launch asked for one, and lowers the count of outstanding kernels. At the end of the next pass it pulses a host wake-up.

Top module: `wg_dispatch_sched`

## Requirements
- R1: After reset, disp_valid, kdone_valid and host_wake are 0, outstanding is 0 and every notify bit is 0.
- R2: A launch sampled at clock edge L arms a pass that starts at edge L+1. When the scheduler was idle, disp_valid is therefore 0 between L and L+1 and 1 after L+1. In any cycle where launch_valid is high, disp_valid is 0.
- R3: The workgroups of a kernel are offered with index 0 fastest, then index 1, then index 2. disp_gid is the linear count of workgroups of that kernel already accepted, so the workgroup with linear number g has wg0 = g mod n0, wg1 = (g / n0) mod n1 and wg2 = g / (n0*n1). disp_kid carries the kernel slot.
- R4: A kernel is offered exactly n0*n1*n2 accepted workgroups. After the last one is accepted it leaves the queue and is never offered again.
- R5: When a workgroup is offered with disp_accept low, the kernel moves to the back of the queue and the pass goes on with the next queued kernel in the same pass.
- R6: A pass ends as soon as the number of queued kernels is no longer above the number of refusals in that pass. After it ends, no workgroup is offered until a launch or a completion report arms a new pass.
- R7: A completion report that brings a kernel's completed count to n0*n1*n2 makes kdone_valid 1 for one cycle after the edge that samples the report, with kdone_kid equal to that kernel. Other reports leave kdone_valid 0.
- R8: When a kernel completes, its notify bit becomes 1 if it was launched with launch_notify = 1 and stays 0 otherwise. Launching a slot clears its notify bit.
- R9: outstanding goes up by one on each launch and down by one on each kernel completion.
- R10: host_wake pulses for one cycle at the end of a pass if at least one kernel completed since the end of the previous pass. A pass with no completions behind it does not pulse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch a kernel this cycle |
| launch_kid | input | KW | Kernel slot being launched |
| launch_n0 | input | DW | Workgroup count along index 0 (nonzero) |
| launch_n1 | input | DW | Workgroup count along index 1 (nonzero) |
| launch_n2 | input | DW | Workgroup count along index 2 (nonzero) |
| launch_notify | input | 1 | Raise the notify bit when this kernel finishes |
| disp_valid | output | 1 | A workgroup is offered to the compute units |
| disp_accept | input | 1 | Compute units take the offered workgroup (low means refused) |
| disp_kid | output | KW | Kernel slot of the offered workgroup |
| disp_wg0 | output | DW | Workgroup index 0 |
| disp_wg1 | output | DW | Workgroup index 1 |
| disp_wg2 | output | DW | Workgroup index 2 |
| disp_gid | output | 3*DW | Linear workgroup number within the kernel |
| wgdone_valid | input | 1 | A workgroup has completed |
| wgdone_kid | input | KW | Kernel slot of the completed workgroup |
| kdone_valid | output | 1 | A kernel finished |
| kdone_kid | output | KW | Slot of the finished kernel |
| notify | output | NK | Per-slot notify bits |
| outstanding | output | KW+1 | Number of launched kernels not yet finished |
| host_wake | output | 1 | Host wake-up pulse at the end of a pass |

## Verification
The bench sweeps every grid shape with up to three workgroups per index. It checks the offered index triple and linear number against arithmetic on the accept count. A design that walked the wrong index fastest, or kept offering after the last workgroup, shows up on the first shape with more than one workgroup along an index. A second scenario refuses one kernel while two others wait behind it. A design that blocked on the refused head would starve the others. A design that ended the pass too early or too late would show a wrong refusal count, or offers after the pass. Completion checks look at the exact cycle of kdone_valid, the notify bit against the launch option and the outstanding count, and count host_wake pulses both after completions and in a pass with none.

// File: rtl/wg_dispatch_sched.sv
module wg_dispatch_sched #(
  parameter int NK = 4,
  parameter int DW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  input  logic [$clog2(NK)-1:0] launch_kid,
  input  logic [DW-1:0]     launch_n0,
  input  logic [DW-1:0]     launch_n1,
  input  logic [DW-1:0]     launch_n2,
  input  logic              launch_notify,
  output logic              disp_valid,
  input  logic              disp_accept,
  output logic [$clog2(NK)-1:0] disp_kid,
  output logic [DW-1:0]     disp_wg0,
  output logic [DW-1:0]     disp_wg1,
  output logic [DW-1:0]     disp_wg2,
  output logic [3*DW-1:0]   disp_gid,
  input  logic              wgdone_valid,
  input  logic [$clog2(NK)-1:0] wgdone_kid,
  output logic              kdone_valid,
  output logic [$clog2(NK)-1:0] kdone_kid,
  output logic [NK-1:0]     notify,
  output logic [$clog2(NK):0] outstanding,
  output logic              host_wake
);
  localparam int KW = $clog2(NK);
  localparam int GW = 3 * DW;
  localparam int CW = KW + 1;

  logic [DW-1:0] n0_q [NK];
  logic [DW-1:0] n1_q [NK];
  logic [DW-1:0] n2_q [NK];
  logic [DW-1:0] i0_q [NK];
  logic [DW-1:0] i1_q [NK];
  logic [DW-1:0] i2_q [NK];
  logic [GW-1:0] gid_q [NK];
  logic [GW-1:0] tot_q [NK];
  logic [GW-1:0] cmp_q [NK];
  logic [NK-1:0] rem_q, nen_q;
  logic [KW-1:0] fifo_q [NK];
  logic [KW-1:0] head_q;
  logic [CW-1:0] cnt_q, fail_q;
  logic          run_q, pend_q, seen_q;

  wire [KW-1:0] cur  = fifo_q[head_q];
  wire [KW-1:0] tail = head_q + cnt_q[KW-1:0];
  wire busy     = run_q && !launch_valid && (cnt_q > fail_q);
  wire pass_end = run_q && !launch_valid && (cnt_q <= fail_q);
  wire start    = !run_q && pend_q;

  wire wrap0 = (i0_q[cur] + 1'b1) == n0_q[cur];
  wire wrap1 = (i1_q[cur] + 1'b1) == n1_q[cur];
  wire wrap2 = (i2_q[cur] + 1'b1) == n2_q[cur];
  wire last  = wrap0 && wrap1 && wrap2;

  assign disp_valid = busy && rem_q[cur];
  assign disp_kid   = cur;
  assign disp_wg0   = i0_q[cur];
  assign disp_wg1   = i1_q[cur];
  assign disp_wg2   = i2_q[cur];
  assign disp_gid   = gid_q[cur];

  wire take   = disp_valid && disp_accept;
  wire refuse = disp_valid && !disp_accept;
  wire drop   = (busy && !rem_q[cur]) || (take && last);

  wire [GW-1:0] cmp_inc = cmp_q[wgdone_kid] + 1'b1;
  wire fin = wgdone_valid && (cmp_inc == tot_q[wgdone_kid]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; pend_q <= 1'b0; seen_q <= 1'b0;
      head_q <= '0; cnt_q <= '0; fail_q <= '0;
      kdone_valid <= 1'b0; kdone_kid <= '0;
      outstanding <= '0; host_wake <= 1'b0;
      for (int k = 0; k < NK; k++) fifo_q[k] <= '0;
    end else begin
      pend_q <= launch_valid || wgdone_valid || (pend_q && !start);
      if (start) begin
        run_q  <= 1'b1;
        fail_q <= '0;
      end else if (pass_end) begin
        run_q <= 1'b0;
      end
      if (launch_valid) begin
        fifo_q[tail] <= launch_kid;
        cnt_q        <= cnt_q + 1'b1;
      end else if (refuse) begin
        fifo_q[tail] <= cur;
        head_q       <= head_q + 1'b1;
        fail_q       <= fail_q + 1'b1;
      end else if (drop) begin
        head_q <= head_q + 1'b1;
        cnt_q  <= cnt_q - 1'b1;
      end
      host_wake   <= pass_end && seen_q;
      seen_q      <= fin || (seen_q && !pass_end);
      kdone_valid <= fin;
      if (fin) kdone_kid <= wgdone_kid;
      case ({launch_valid, fin})
        2'b10:   outstanding <= outstanding + 1'b1;
        2'b01:   outstanding <= outstanding - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0; nen_q <= '0; notify <= '0;
      for (int k = 0; k < NK; k++) begin
        n0_q[k] <= '0; n1_q[k] <= '0; n2_q[k] <= '0;
        i0_q[k] <= '0; i1_q[k] <= '0; i2_q[k] <= '0;
        gid_q[k] <= '0; tot_q[k] <= '0; cmp_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < NK; k++) begin
        if (launch_valid && launch_kid == KW'(k)) begin
          n0_q[k] <= launch_n0; n1_q[k] <= launch_n1; n2_q[k] <= launch_n2;
          i0_q[k] <= '0; i1_q[k] <= '0; i2_q[k] <= '0;
          gid_q[k] <= '0; cmp_q[k] <= '0;
          tot_q[k] <= GW'(launch_n0) * GW'(launch_n1) * GW'(launch_n2);
          rem_q[k] <= 1'b1;
          nen_q[k] <= launch_notify;
          notify[k] <= 1'b0;
        end else begin
          if (take && cur == KW'(k)) begin
            gid_q[k] <= gid_q[k] + 1'b1;
            i0_q[k]  <= wrap0 ? '0 : i0_q[k] + 1'b1;
            if (wrap0) i1_q[k] <= wrap1 ? '0 : i1_q[k] + 1'b1;
            if (wrap0 && wrap1) i2_q[k] <= wrap2 ? '0 : i2_q[k] + 1'b1;
            if (last) rem_q[k] <= 1'b0;
          end
          if (wgdone_valid && wgdone_kid == KW'(k)) begin
            cmp_q[k] <= cmp_inc;
            if (fin) notify[k] <= nen_q[k];
          end
        end
      end
    end
  end

  // R6
  fail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q <= cnt_q);
  // R9
  outstanding_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= CW'(NK));
  // R3
  wg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_wg0 < n0_q[disp_kid] && disp_wg1 < n1_q[disp_kid]
                    && disp_wg2 < n2_q[disp_kid]));
  // R4
  gid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> disp_gid < tot_q[disp_kid]);
  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kdone_valid |-> $past(wgdone_valid));
  // R10
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wake |-> !run_q && !disp_valid);
  // R2
  launch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |-> !disp_valid);
endmodule

// File: tb/wg_dispatch_sched_bench.sv
module wg_dispatch_sched_bench;
  localparam int NK = 4;
  localparam int DW = 3;

  logic clk = 0, rst_n = 0;
  logic launch_valid = 0, launch_notify = 0;
  logic [1:0] launch_kid = 0;
  logic [DW-1:0] launch_n0 = 0, launch_n1 = 0, launch_n2 = 0;
  logic disp_valid, disp_accept = 0;
  logic [1:0] disp_kid;
  logic [DW-1:0] disp_wg0, disp_wg1, disp_wg2;
  logic [3*DW-1:0] disp_gid;
  logic wgdone_valid = 0;
  logic [1:0] wgdone_kid = 0;
  logic kdone_valid;
  logic [1:0] kdone_kid;
  logic [NK-1:0] notify;
  logic [2:0] outstanding;
  logic host_wake;

  wg_dispatch_sched #(.NK(NK), .DW(DW)) u_wg_dispatch_sched (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int bn0[NK], bn1[NK], bn2[NK], btot[NK], cnt[NK], bd[NK];
  bit bnen[NK];
  bit refuse[NK];
  int cq[1024];
  int cq_wr = 0, cq_rd = 0;
  int refusals = 0, offers = 0, hw_cnt = 0, exp_out = 0, cycles = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (host_wake) hw_cnt++;
    if (cycles > 150000) begin
      chk(0, "watchdog", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // compute-unit model: accept unless the slot is marked refused
  always @(negedge clk) begin
    #1;
    if (disp_valid && !refuse[disp_kid]) begin
      automatic int k = disp_kid;
      automatic int c = cnt[k];
      automatic int e = ((c / (bn0[k] * bn1[k])) << 12) | (((c / bn0[k]) % bn1[k]) << 8)
                        | ((c % bn0[k]) << 4);
      automatic int a = (disp_wg2 << 12) | (disp_wg1 << 8) | (disp_wg0 << 4);
      disp_accept = 1;
      chk(a == e && disp_gid == c, "R3 walk order", a + disp_gid, e + c);
      chk(c < btot[k], "R4 no extra workgroup", c, btot[k]);
      cnt[k]++;
      cq[cq_wr % 1024] = k;
      cq_wr++;
      offers++;
    end else begin
      disp_accept = 0;
      if (disp_valid) begin refusals++; offers++; end
    end
  end

  task automatic launch(input int k, input int a, input int b, input int c, input bit ne);
    @(negedge clk);
    launch_valid = 1; launch_kid = k[1:0];
    launch_n0 = a[DW-1:0]; launch_n1 = b[DW-1:0]; launch_n2 = c[DW-1:0];
    launch_notify = ne;
    bn0[k] = a; bn1[k] = b; bn2[k] = c; btot[k] = a * b * c;
    cnt[k] = 0; bd[k] = 0; bnen[k] = ne;
    exp_out++;
    @(negedge clk);
    launch_valid = 0;
  endtask

  task automatic drain();
    while (cq_rd != cq_wr) begin
      automatic int k = cq[cq_rd % 1024];
      automatic bit last;
      cq_rd++;
      @(negedge clk);
      wgdone_valid = 1; wgdone_kid = k[1:0];
      bd[k]++;
      last = (bd[k] == btot[k]);
      @(negedge clk);
      wgdone_valid = 0;
      #1;
      chk(kdone_valid == last && (!last || kdone_kid == k), "R7 kernel done pulse",
          {kdone_valid, kdone_kid}, {last, k[1:0]});
      if (last) begin
        exp_out--;
        chk(outstanding == exp_out, "R9 outstanding after done", outstanding, exp_out);
        chk(notify[k] == bnen[k], "R8 notify on done", notify[k], bnen[k]);
      end
    end
  endtask

  initial begin
    int hw0;
    for (int k = 0; k < NK; k++) begin
      bn0[k] = 1; bn1[k] = 1; bn2[k] = 1; btot[k] = 0; cnt[k] = 0; bd[k] = 0;
      refuse[k] = 0; bnen[k] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(!disp_valid && !kdone_valid && !host_wake && outstanding == 0 && notify == 0,
        "R1 reset state", {disp_valid, kdone_valid, host_wake, outstanding, notify}, 0);
    rst_n = 1;

    // R2 launch timing, R3/R4 walk, R8/R9/R10 completion
    hw0 = hw_cnt;
    launch(2, 3, 2, 2, 1);
    #1 chk(!disp_valid, "R2 idle one cycle after launch", disp_valid, 0);
    @(negedge clk);
    #1 chk(disp_valid, "R2 offer after pass start", disp_valid, 1);
    chk(outstanding == 1, "R9 outstanding after launch", outstanding, 1);
    repeat (30) @(negedge clk);
    chk(cnt[2] == 12, "R4 all workgroups issued", cnt[2], 12);
    #1 chk(!disp_valid, "R4 kernel leaves queue", disp_valid, 0);
    drain();
    repeat (5) @(negedge clk);
    chk(hw_cnt > hw0, "R10 wake after completion", hw_cnt - hw0, 1);

    // R5/R6 requeue on refusal
    for (int k = 0; k < NK; k++) refuse[k] = 1;
    launch(0, 2, 2, 1, 0);
    launch(1, 1, 1, 3, 1);
    repeat (6) @(negedge clk);
    refuse[1] = 0; refuse[2] = 0; refuse[3] = 0;
    refusals = 0;
    hw0 = hw_cnt;
    launch(2, 1, 1, 1, 0);
    repeat (10) @(negedge clk);
    chk(cnt[1] == 3 && cnt[2] == 1, "R5 later kernels served", cnt[1] * 10 + cnt[2], 31);
    chk(cnt[0] == 0, "R5 refused kernel held", cnt[0], 0);
    chk(refusals == 1, "R6 one refusal per pass", refusals, 1);
    chk(hw_cnt == hw0, "R10 no wake without completion", hw_cnt - hw0, 0);
    chk(outstanding == 3, "R9 three outstanding", outstanding, 3);
    offers = 0;
    repeat (30) @(negedge clk);
    chk(offers == 0, "R6 no offers after pass end", offers, 0);
    hw0 = hw_cnt;
    drain();
    repeat (5) @(negedge clk);
    chk(hw_cnt > hw0, "R10 wake after kernels 1 and 2", hw_cnt - hw0, 1);
    refuse[0] = 0;
    launch(3, 1, 1, 1, 1);
    repeat (12) @(negedge clk);
    chk(cnt[0] == 4 && cnt[3] == 1, "R5 requeued kernel resumes", cnt[0] * 10 + cnt[3], 41);
    drain();
    chk(outstanding == 0, "R9 all retired", outstanding, 0);

    // sweep over grid shapes
    for (int s = 0; s < 27; s++) begin
      automatic int a = s % 3 + 1;
      automatic int b = (s / 3) % 3 + 1;
      automatic int c = s / 9 + 1;
      automatic int k = s % NK;
      launch(k, a, b, c, s[0]);
      #1 chk(notify[k] == 0, "R8 launch clears notify", notify[k], 0);
      repeat (40) @(negedge clk);
      chk(cnt[k] == a * b * c, "R4 sweep count", cnt[k], a * b * c);
      drain();
    end
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule